// File: doc/BRIEF.md
# Monochrome Color Expander

The block turns a one-bit-per-pixel bitmap into colored pixels. The host first sets up a job through a small register write bus. It writes a foreground color, a background color, the rectangle size and the pixel depth. A write to the control register then starts the job. The host streams the bitmap as 32-bit words through a data port that has a ready signal. Each bit becomes one pixel of the foreground or background color. Pixels leave in raster order on a valid/ready stream, with flags that mark the end of each row and the final pixel of the rectangle.

The bitmap is one continuous run of bits. A new row does not start on a word or byte boundary. The host rounds the amount of data it sends to a fixed word count that is larger than the bits strictly need. The block takes those extra words, throws them away, and closes the job only when every pixel has been sent and the full word count has arrived. A single word buffer holds the word being unpacked. The data port stalls whenever that buffer is full and the pixel output is stalled.

Top module: `mono_color_expander`

## Requirements
- R1: After reset `busy_o` and `pix_valid_o` are 0 and `data_ready_o` is 1.
- R2: Register addresses are: 0 = foreground color, 1 = background color, 2 = size (width-1 in bits [11:0], height-1 in bits [27:16]), 3 = control (depth code in bits [1:0]). A write to address 3 while idle starts a job, and `busy_o` is 1 from the next cycle.
- R3: While `busy_o` is 1, register writes to any address are ignored, and a control write does not restart the job.
- R4: A source bit of 1 gives the foreground color and a bit of 0 gives the background color.
- R5: Within a data word, bytes are used starting from bits [7:0] and moving upward. Within each byte, bits are used starting from the most significant bit.
- R6: Depth code 0 outputs the low 8 bits of the color. Code 1 outputs the low 16 bits. Codes 2 and 3 output all 32 bits. The unused upper bits are 0.
- R7: Exactly width*height pixels are output, with bits running on across row boundaries with no padding. `pix_eol_o` marks the last pixel of each row and `pix_last_o` marks the final pixel.
- R8: A job takes (width*height+3)/4 data words in total. Words after the first ceil(width*height/32) are accepted and discarded. `busy_o` falls one cycle after the later of these two events: the final pixel transfer or the final expected word.
- R9: While `pix_valid_o` is 1 and `pix_ready_i` is 0, the pixel and its flags stay stable. If the buffer is full and another useful word is still due, `data_ready_o` is 0.
- R10: Data words that arrive while idle are accepted, and no pixel is produced from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| data_valid_i | input | 1 | Bitmap word valid |
| data_i | input | 32 | Bitmap word |
| data_ready_o | output | 1 | Bitmap word accepted when high with valid |
| pix_valid_o | output | 1 | Pixel valid |
| pix_ready_i | input | 1 | Pixel sink ready |
| pix_o | output | 32 | Expanded pixel color |
| pix_eol_o | output | 1 | Last pixel of a row |
| pix_last_o | output | 1 | Last pixel of the rectangle |
| busy_o | output | 1 | Job in progress |

## Verification
Two things can happen in the same cycle. The final bit of the buffered word can leave on a pixel handshake while the next word is loaded on the data port. Separately, discard words can be accepted while pixels are still streaming out. The bench provokes both by keeping the data port busy while it drives `pix_ready_i` with a pseudo-random stall pattern. A scoreboard judges every pixel against colors computed from the bit-order rules, so a lost or repeated bit at a word seam shows up as a mismatch. A separate case holds the sink stalled with a full buffer to confirm that the port back-pressures.

// File: rtl/mce_pkg.sv
package mce_pkg;
  typedef enum logic [1:0] {
    DEPTH_8   = 2'd0,
    DEPTH_16  = 2'd1,
    DEPTH_32  = 2'd2,
    DEPTH_32X = 2'd3
  } depth_e;

  localparam logic [1:0] ADDR_FG  = 2'd0;
  localparam logic [1:0] ADDR_BG  = 2'd1;
  localparam logic [1:0] ADDR_DIM = 2'd2;
  localparam logic [1:0] ADDR_CTL = 2'd3;

  function automatic logic [31:0] depth_mask(depth_e d);
    case (d)
      DEPTH_8:  return 32'h0000_00ff;
      DEPTH_16: return 32'h0000_ffff;
      default:  return 32'hffff_ffff;
    endcase
  endfunction
endpackage

// File: rtl/mce_regs.sv
module mce_regs
  import mce_pkg::*;
#(
  parameter int DIM_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  input  logic             busy_i,
  output logic [31:0]      fg_o,
  output logic [31:0]      bg_o,
  output logic [DIM_W-1:0] w_m1_o,
  output logic [DIM_W-1:0] h_m1_o,
  output depth_e           depth_o,
  output logic             start_o
);
  logic wr_ok;
  logic unused_bits;

  assign wr_ok       = reg_we_i && !busy_i;
  assign start_o     = wr_ok && (reg_addr_i == ADDR_CTL);
  assign unused_bits = ^{reg_wdata_i[15:DIM_W], reg_wdata_i[31:16+DIM_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fg_o    <= '0;
      bg_o    <= '0;
      w_m1_o  <= '0;
      h_m1_o  <= '0;
      depth_o <= DEPTH_8;
    end else if (wr_ok) begin
      case (reg_addr_i)
        ADDR_FG:  fg_o <= reg_wdata_i;
        ADDR_BG:  bg_o <= reg_wdata_i;
        ADDR_DIM: begin
          w_m1_o <= reg_wdata_i[DIM_W-1:0];
          h_m1_o <= reg_wdata_i[16 +: DIM_W];
        end
        default:  depth_o <= depth_e'(reg_wdata_i[1:0]);
      endcase
    end
  end

  assert_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && reg_we_i |=> $stable(fg_o) && $stable(bg_o) && $stable(w_m1_o)
                           && $stable(h_m1_o) && $stable(depth_o));
endmodule

// File: rtl/mce_raster.sv
module mce_raster #(
  parameter int DIM_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             fire_i,
  input  logic [DIM_W-1:0] w_m1_i,
  input  logic [DIM_W-1:0] h_m1_i,
  output logic             eol_o,
  output logic             last_o,
  output logic             done_o
);
  logic [DIM_W-1:0] x_q, y_q;

  assign eol_o  = (x_q == w_m1_i);
  assign last_o = eol_o && (y_q == h_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q    <= '0;
      y_q    <= '0;
      done_o <= 1'b0;
    end else if (start_i) begin
      x_q    <= '0;
      y_q    <= '0;
      done_o <= 1'b0;
    end else if (fire_i) begin
      if (eol_o) begin
        x_q <= '0;
        y_q <= y_q + 1'b1;
        if (last_o) done_o <= 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end

  assert_no_fire_after_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |-> !fire_i);
endmodule

// File: rtl/mce_unpack.sv
module mce_unpack #(
  parameter int DIM_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIM_W-1:0]  w_m1_i,
  input  logic [DIM_W-1:0]  h_m1_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              data_ready_o,
  input  logic              pix_ready_i,
  input  logic              last_i,
  input  logic              done_i,
  output logic              bit_o,
  output logic              bit_vld_o,
  output logic              busy_o
);
  localparam int AREA_W = 2 * DIM_W + 1;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  logic [AREA_W-1:0] area_c, used_c, exp_c;
  logic [AREA_W-1:0] words_used_q, words_exp_q, words_rx_q;
  logic [DATA_W-1:0] buf_q;
  logic              buf_vld_q, active_q;
  logic [IDX_W-1:0]  idx_q, sel_c;
  logic              useful, fire, drain, take, load;

  assign area_c = (AREA_W'(w_m1_i) + AREA_W'(1)) * (AREA_W'(h_m1_i) + AREA_W'(1));
  assign used_c = (area_c + AREA_W'(DATA_W - 1)) / AREA_W'(DATA_W);
  assign exp_c  = (area_c + AREA_W'(3)) >> 2;

  assign useful       = words_rx_q < words_used_q;
  assign bit_vld_o    = active_q && buf_vld_q && !done_i;
  assign fire         = bit_vld_o && pix_ready_i;
  assign drain        = fire && (idx_q == IDX_LAST);
  assign data_ready_o = !active_q || !useful || !buf_vld_q || drain;
  assign take         = active_q && data_valid_i && data_ready_o;
  assign load         = take && useful;
  assign busy_o       = active_q;

  // byte order ascending, bit order MSB first within a byte
  assign sel_c = {idx_q[IDX_W-1:3], ~idx_q[2:0]};
  assign bit_o = buf_q[sel_c];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q     <= 1'b0;
      buf_vld_q    <= 1'b0;
      buf_q        <= '0;
      idx_q        <= '0;
      words_rx_q   <= '0;
      words_used_q <= '0;
      words_exp_q  <= '0;
    end else if (start_i) begin
      active_q     <= 1'b1;
      buf_vld_q    <= 1'b0;
      idx_q        <= '0;
      words_rx_q   <= '0;
      words_used_q <= used_c;
      words_exp_q  <= exp_c;
    end else if (active_q) begin
      if (take && words_rx_q != '1) words_rx_q <= words_rx_q + 1'b1;
      if (load) begin
        buf_q     <= data_i;
        buf_vld_q <= 1'b1;
        idx_q     <= '0;
      end else if (fire) begin
        idx_q <= idx_q + 1'b1;
        if (idx_q == IDX_LAST || last_i) buf_vld_q <= 1'b0;
      end
      if (done_i && words_rx_q >= words_exp_q) active_q <= 1'b0;
    end
  end

  assert_valid_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o && !pix_ready_i |=> bit_vld_o);
  assert_backpressure_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o && !pix_ready_i && useful |-> !data_ready_o);
  assert_end_after_pixels_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_i);
endmodule

// File: rtl/mono_color_expander.sv
module mono_color_expander
  import mce_pkg::*;
#(
  parameter int DIM_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              data_ready_o,
  output logic              pix_valid_o,
  input  logic              pix_ready_i,
  output logic [31:0]       pix_o,
  output logic              pix_eol_o,
  output logic              pix_last_o,
  output logic              busy_o
);
  logic [31:0]      fg, bg;
  logic [DIM_W-1:0] w_m1, h_m1;
  depth_e           depth;
  logic             start, src_bit, done, fire;

  mce_regs #(.DIM_W(DIM_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .busy_i (busy_o),
    .fg_o   (fg),
    .bg_o   (bg),
    .w_m1_o (w_m1),
    .h_m1_o (h_m1),
    .depth_o(depth),
    .start_o(start)
  );

  mce_unpack #(.DIM_W(DIM_W), .DATA_W(DATA_W)) u_unpack (
    .clk_i, .rst_ni,
    .start_i     (start),
    .w_m1_i      (w_m1),
    .h_m1_i      (h_m1),
    .data_valid_i,
    .data_i,
    .data_ready_o,
    .pix_ready_i,
    .last_i      (pix_last_o),
    .done_i      (done),
    .bit_o       (src_bit),
    .bit_vld_o   (pix_valid_o),
    .busy_o
  );

  assign fire = pix_valid_o && pix_ready_i;

  mce_raster #(.DIM_W(DIM_W)) u_raster (
    .clk_i, .rst_ni,
    .start_i(start),
    .fire_i (fire),
    .w_m1_i (w_m1),
    .h_m1_i (h_m1),
    .eol_o  (pix_eol_o),
    .last_o (pix_last_o),
    .done_o (done)
  );

  assign pix_o = (src_bit ? fg : bg) & depth_mask(depth);

  assert_pix_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_ready_i |=> $stable(pix_o) && $stable(pix_eol_o) && $stable(pix_last_o));
  assert_quiet_after_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && pix_last_o |=> !pix_valid_o);
endmodule

// File: tb/mono_color_expander_tb.sv
module mono_color_expander_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        data_valid_i = 1'b0;
  logic [31:0] data_i = '0;
  logic        data_ready_o, pix_valid_o, pix_eol_o, pix_last_o, busy_o;
  logic        pix_ready_i = 1'b1;
  logic [31:0] pix_o;

  int checks = 0;
  int fails  = 0;
  logic [33:0] exp_q[$];
  bit stall_en = 0;
  bit hold_low = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  mono_color_expander u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .data_valid_i, .data_i, .data_ready_o,
    .pix_valid_o, .pix_ready_i, .pix_o, .pix_eol_o, .pix_last_o, .busy_o
  );

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // sink ready pattern
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pix_ready_i = hold_low ? 1'b0 : (stall_en ? (lfsr[0] | lfsr[3]) : 1'b1);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && pix_valid_o && pix_ready_i) begin
      if (exp_q.size() == 0) begin
        check(0, "R10", "unexpected pixel", {32'd0, pix_o}, 64'd0);
      end else begin
        logic [33:0] e;
        e = exp_q.pop_front();
        check(pix_o == e[31:0], "R4 R5 R6", "pixel color", {32'd0, pix_o}, {32'd0, e[31:0]});
        check({pix_last_o, pix_eol_o} == e[33:32], "R7", "eol/last flags",
              {62'd0, pix_last_o, pix_eol_o}, {62'd0, e[33:32]});
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    check(0, "WD", "watchdog expired", 64'd0, 64'd1);
    summary();
  end

  function automatic logic [31:0] gen_word(int seed, int i);
    return (32'(seed) * 32'h0100_0193) ^ (32'(i) * 32'h9E37_79B9) ^ {16'(i), 16'h5A3C};
  endfunction

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk); #1;
    reg_we_i = 1'b0;
  endtask

  task automatic push_word(logic [31:0] w);
    bit acc;
    data_valid_i = 1'b1; data_i = w;
    do begin
      @(negedge clk); acc = data_ready_o;
      @(posedge clk); #1;
    end while (!acc);
    data_valid_i = 1'b0;
  endtask

  task automatic wait_drain();
    for (int n = 0; n < 5000 && exp_q.size() != 0; n++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic run_job(int w, int h, int dep, logic [31:0] fg, logic [31:0] bg,
                         int seed, bit mid, bit stall, bit probe);
    int area, used, expw;
    logic [31:0] mask;
    area = w * h;
    used = (area + 31) / 32;
    expw = (area + 3) / 4;
    mask = (dep == 0) ? 32'h0000_00ff : (dep == 1) ? 32'h0000_ffff : 32'hffff_ffff;
    stall_en = stall;
    reg_write(2'd0, fg);
    reg_write(2'd1, bg);
    reg_write(2'd2, {4'd0, 12'(h - 1), 4'd0, 12'(w - 1)});
    for (int p = 0; p < area; p++) begin
      logic [31:0] wd;
      int k;
      logic b;
      wd = gen_word(seed, p / 32);
      k = p % 32;
      b = wd[(k / 8) * 8 + 7 - (k % 8)];
      exp_q.push_back({(p == area - 1), ((p % w) == w - 1), (b ? fg : bg) & mask});
    end
    reg_write(2'd3, 32'(dep));
    check(busy_o == 1'b1, "R2", "busy after start", {63'd0, busy_o}, 64'd1);
    for (int i = 0; i < expw - 1; i++) begin
      if (probe && i == 0) hold_low = 1;
      push_word(gen_word(seed, i));
      if (probe && i == 0) begin
        logic [31:0] first;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pix_valid_o == 1'b1, "R9", "valid while stalled", {63'd0, pix_valid_o}, 64'd1);
        check(data_ready_o == 1'b0, "R9", "port stalls when buffer full",
              {63'd0, data_ready_o}, 64'd0);
        first = pix_o;
        @(negedge clk);
        check(pix_o == first, "R9", "pixel stable while stalled", {32'd0, pix_o}, {32'd0, first});
        @(posedge clk); #1;
        hold_low = 0;
      end
      if (mid && i == 0) begin
        reg_write(2'd0, ~fg);
        reg_write(2'd1, ~bg);
        reg_write(2'd3, 32'd2);
        check(busy_o == 1'b1, "R3", "control write while busy ignored", {63'd0, busy_o}, 64'd1);
      end
    end
    if (expw > used) begin
      wait_drain();
      @(posedge clk); #1;
      check(busy_o == 1'b1, "R8", "busy until all words arrive", {63'd0, busy_o}, 64'd1);
      push_word(gen_word(seed, expw - 1));
      @(posedge clk); #1;
      check(busy_o == 1'b0, "R8", "busy falls after last word", {63'd0, busy_o}, 64'd0);
    end else begin
      push_word(gen_word(seed, expw - 1));
      wait_drain();
      repeat (2) @(posedge clk); #1;
      check(busy_o == 1'b0, "R8", "busy falls after last pixel", {63'd0, busy_o}, 64'd0);
    end
    check(exp_q.size() == 0, "R7", "all pixels delivered", 64'(exp_q.size()), 64'd0);
    stall_en = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(busy_o == 1'b0, "R1", "busy in reset", {63'd0, busy_o}, 64'd0);
    check(pix_valid_o == 1'b0, "R1", "valid in reset", {63'd0, pix_valid_o}, 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(data_ready_o == 1'b1, "R1", "ready after reset", {63'd0, data_ready_o}, 64'd1);

    // R10: words while idle are swallowed
    push_word(32'hFFFF_FFFF);
    push_word(32'h1234_5678);
    repeat (3) @(posedge clk); #1;
    check(pix_valid_o == 1'b0 && busy_o == 1'b0, "R10", "no pixels from idle words",
          {62'd0, pix_valid_o, busy_o}, 64'd0);

    run_job(10, 3, 0, 32'h1234_5678, 32'h9ABC_DEF0, 1, 0, 0, 0);
    run_job(33, 2, 1, 32'hCAFE_BEEF, 32'h0BAD_F00D, 2, 1, 1, 0);
    run_job(5, 7, 2, 32'hFFFF_0000, 32'h0000_FFFF, 3, 0, 1, 0);
    run_job(1, 1, 3, 32'h8765_4321, 32'h1111_2222, 4, 0, 0, 0);
    run_job(64, 1, 2, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 5, 0, 0, 1);
    run_job(40, 5, 0, 32'h0000_00C3, 32'h0000_003C, 6, 1, 1, 0);

    repeat (4) @(posedge clk);
    summary();
  end
endmodule